// File: doc/BRIEF.md
# Three-Phase Register Processor Core

This block is a small processor core. It steps through a fetch, decode and execute loop over a private instruction memory of 1024 words. Each word holds one 32-bit instruction, and instructions are addressed in whole words starting at address 0. The core has sixteen 32-bit registers. Register 15 acts as the program counter and register 13 is kept for use as a stack pointer. An arithmetic and logic unit supports nine data-processing operations, in two instruction classes: register-immediate and three-register.

The host uses the core in four steps:
1. Hold the core in reset and write program words through the load port.
2. Release reset and pulse `start`, with the program length presented on `progLen`.
3. Wait for `done`. The core raises it once the program counter is at or beyond that length.
4. Read any register at any time through the debug read port.

Opcodes outside the supported set, and register fields that name no register, complete as no-ops and set a sticky flag.

Top module: `regcore_top`

## Requirements
- R1: The instruction format is: opcode in bits 7:0, destination field in bits 15:8, first field in bits 23:16, second field in bits 31:24. With this format the words 0x0015010D, 0x0015020D and 0x02010304 leave R3 equal to 42.
- R2: The three-register opcodes write the destination from the registers named by the first (a) and second (b) fields, with 32-bit wrap-around: 0 a AND b, 1 a XOR b, 2 a−b, 3 b−a, 4 a+b, 12 a OR b, 14 a AND NOT b.
- R3: Opcode 13 writes the zero-extended 8-bit value in bits 23:16 to the destination, and opcode 15 writes its bitwise complement. Bits 31:24 have no effect for these two opcodes.
- R4: Each fetch reads the word at the R15 address and increments R15 by one before execute. Reading R15 as a source therefore yields the instruction's own address plus one, and writing R15 sets the next fetch address.
- R5: After a start pulse is seen, the core spends one check cycle and then three cycles per instruction. `done` rises the cycle after the execute step (or the check cycle) in which R15 ≥ `progLen`, and it stays high until reset.
- R6: An opcode other than the nine listed, or a used register field with any of bits 7:4 set, writes no register and sets `illegalOp`. The flag stays set until reset.
- R7: Load port writes take effect only while `rstN` is low. A load strobe with `rstN` high leaves memory unchanged.
- R8: After reset all sixteen registers read zero, and `busy`, `done` and `illegalOp` are low.
- R9: `dbgData` shows the register selected by `dbgSel` in the same cycle.
- R10: With `progLen` of 0, `done` rises two edges after start and no instruction runs. A start pulse while `done` is high changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset; also enables program loading |
| loadEn | input | 1 | Program word write strobe |
| loadAddr | input | 10 | Word address for the program write |
| loadData | input | 32 | Program word |
| start | input | 1 | Begin execution from the current R15 |
| progLen | input | 11 | Stop address, sampled at start |
| dbgSel | input | 4 | Register number to observe |
| dbgData | output | 32 | Value of the selected register |
| busy | output | 1 | Core is checking or executing |
| done | output | 1 | Program counter reached the stop address |
| illegalOp | output | 1 | Sticky bad-instruction flag |

## Verification
The assertions assume that `start` arrives only in idle or done, and that R15 is never written while a fetch is in progress. The controller guarantees the second point by design. The bench raises `start` only after reset or after completion, and loads programs only while the core is in reset. Every program the bench builds stays inside the loaded words, and every jump it makes lands at or below the stop address, so each run ends through the length comparison.

// File: rtl/regcore_pkg.sv
`timescale 1ns/1ps
package regcore_pkg;

  localparam int INSTR_W   = 32;
  localparam int FIELD_W   = 8;
  localparam int REG_COUNT = 16;
  localparam int REG_IDX_W = $clog2(REG_COUNT);
  localparam int PC_INDEX  = REG_COUNT - 1;

  typedef enum logic [FIELD_W-1:0] {
    OP_AND = 8'd0,
    OP_EOR = 8'd1,
    OP_SUB = 8'd2,
    OP_RSB = 8'd3,
    OP_ADD = 8'd4,
    OP_ORR = 8'd12,
    OP_MOV = 8'd13,
    OP_BIC = 8'd14,
    OP_MVN = 8'd15
  } opcode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH,
    ST_DECODE,
    ST_EXEC,
    ST_DONE
  } state_e;

  typedef struct packed {
    logic armLimit;
    logic fetch;
    logic decode;
    logic exec;
  } strobes_t;

endpackage

// File: rtl/regcore_imem.sv
`timescale 1ns/1ps
module regcore_imem #(
  parameter int WORDS  = 1024,
  parameter int WIDTH  = 32,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData
);

  logic [WIDTH-1:0] store [WORDS];

  always_ff @(posedge clk) begin
    if (wrEn) store[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rdEn) rdData <= store[rdAddr];
  end

endmodule

// File: rtl/regcore_alu.sv
`timescale 1ns/1ps
module regcore_alu
  import regcore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [INSTR_W-1:0]   instr,
  input  logic [XLEN-1:0]      opA,
  input  logic [XLEN-1:0]      opB,
  output logic [XLEN-1:0]      result,
  output logic [REG_IDX_W-1:0] dstIdx,
  output logic                 legal
);

  logic [FIELD_W-1:0] opcode;
  logic [FIELD_W-1:0] dstField;
  logic [FIELD_W-1:0] srcAField;
  logic [FIELD_W-1:0] srcBField;
  logic [XLEN-1:0]    immExt;
  logic               isImmClass;

  assign opcode     = instr[FIELD_W-1:0];
  assign dstField   = instr[2*FIELD_W-1:FIELD_W];
  assign srcAField  = instr[3*FIELD_W-1:2*FIELD_W];
  assign srcBField  = instr[4*FIELD_W-1:3*FIELD_W];
  assign immExt     = XLEN'(srcAField);
  assign isImmClass = (opcode == OP_MOV) || (opcode == OP_MVN);
  assign dstIdx     = dstField[REG_IDX_W-1:0];

  always_comb begin
    legal  = 1'b1;
    result = '0;
    case (opcode)
      OP_AND:  result = opA & opB;
      OP_EOR:  result = opA ^ opB;
      OP_SUB:  result = opA - opB;
      OP_RSB:  result = opB - opA;
      OP_ADD:  result = opA + opB;
      OP_ORR:  result = opA | opB;
      OP_MOV:  result = immExt;
      OP_BIC:  result = opA & ~opB;
      OP_MVN:  result = ~immExt;
      default: legal  = 1'b0;
    endcase
    if (dstField[FIELD_W-1:REG_IDX_W] != '0) legal = 1'b0;
    if (!isImmClass &&
        ((srcAField[FIELD_W-1:REG_IDX_W] != '0) ||
         (srcBField[FIELD_W-1:REG_IDX_W] != '0))) legal = 1'b0;
  end

endmodule

// File: rtl/regcore_dpath.sv
`timescale 1ns/1ps
module regcore_dpath
  import regcore_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MEM_WORDS = 1024,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobes_t             stb,
  input  logic [AW:0]          progLen,
  input  logic [INSTR_W-1:0]   memData,
  output logic [AW-1:0]        memAddr,
  input  logic [REG_IDX_W-1:0] dbgSel,
  output logic [XLEN-1:0]      dbgData,
  output logic                 pcReached,
  output logic                 nextReached,
  output logic                 illegal
);

  logic [XLEN-1:0]    regFile [REG_COUNT];
  logic [AW:0]        limitReg;
  logic [INSTR_W-1:0] instrReg;
  logic [XLEN-1:0]    opAReg;
  logic [XLEN-1:0]    opBReg;
  logic               illegalReg;

  logic [XLEN-1:0]      aluResult;
  logic [REG_IDX_W-1:0] dstIdx;
  logic                 aluLegal;
  logic [XLEN-1:0]      nextPc;
  logic [XLEN-1:0]      curPc;

  regcore_alu #(.XLEN(XLEN)) alu_i (
    .instr  (instrReg),
    .opA    (opAReg),
    .opB    (opBReg),
    .result (aluResult),
    .dstIdx (dstIdx),
    .legal  (aluLegal)
  );

  assign curPc   = regFile[PC_INDEX];
  assign memAddr = curPc[AW-1:0];
  assign dbgData = regFile[dbgSel];
  assign illegal = illegalReg;

  assign nextPc      = (aluLegal && (dstIdx == REG_IDX_W'(PC_INDEX))) ? aluResult : curPc;
  assign pcReached   = curPc  >= XLEN'(limitReg);
  assign nextReached = nextPc >= XLEN'(limitReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < REG_COUNT; i++) regFile[i] <= '0;
    end else if (stb.fetch) begin
      regFile[PC_INDEX] <= curPc + XLEN'(1);
    end else if (stb.exec && aluLegal) begin
      regFile[dstIdx] <= aluResult;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitReg   <= '0;
      instrReg   <= '0;
      opAReg     <= '0;
      opBReg     <= '0;
      illegalReg <= 1'b0;
    end else begin
      if (stb.armLimit) limitReg <= progLen;
      if (stb.decode) begin
        instrReg <= memData;
        opAReg   <= regFile[memData[2*FIELD_W+REG_IDX_W-1:2*FIELD_W]];
        opBReg   <= regFile[memData[3*FIELD_W+REG_IDX_W-1:3*FIELD_W]];
      end
      if (stb.exec && !aluLegal) illegalReg <= 1'b1;
    end
  end

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    stb.fetch |=> regFile[PC_INDEX] == $past(regFile[PC_INDEX]) + XLEN'(1)); // R4

  AST_PC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.fetch && !stb.exec) |=> $stable(regFile[PC_INDEX])); // R5

  AST_ILLEGAL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    illegalReg |=> illegalReg); // R6

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (stb.exec && !aluLegal) |=> $stable(regFile[PC_INDEX])); // R6

endmodule

// File: rtl/regcore_ctrl.sv
`timescale 1ns/1ps
module regcore_ctrl
  import regcore_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     pcReached,
  input  logic     nextReached,
  output strobes_t stb,
  output logic     busy,
  output logic     done
);

  state_e state;
  state_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (start) stateNext = ST_CHECK;
      ST_CHECK:  stateNext = pcReached ? ST_DONE : ST_FETCH;
      ST_FETCH:  stateNext = ST_DECODE;
      ST_DECODE: stateNext = ST_EXEC;
      ST_EXEC:   stateNext = nextReached ? ST_DONE : ST_FETCH;
      ST_DONE:   stateNext = ST_DONE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb          = '0;
    stb.armLimit = (state == ST_IDLE) && start;
    stb.fetch    = (state == ST_FETCH);
    stb.decode   = (state == ST_DECODE);
    stb.exec     = (state == ST_EXEC);
  end

  assign done = (state == ST_DONE);
  assign busy = (state != ST_IDLE) && (state != ST_DONE);

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done); // R5

  AST_FETCH_TO_DECODE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FETCH) |=> (state == ST_DECODE)); // R5

  AST_DECODE_TO_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DECODE) |=> (state == ST_EXEC)); // R5

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && start) |=> (state == ST_DONE)); // R10

endmodule

// File: rtl/regcore_top.sv
`timescale 1ns/1ps
module regcore_top
  import regcore_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MEM_WORDS = 1024,
  localparam int AW       = $clog2(MEM_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [AW-1:0]        loadAddr,
  input  logic [INSTR_W-1:0]   loadData,
  input  logic                 start,
  input  logic [AW:0]          progLen,
  input  logic [REG_IDX_W-1:0] dbgSel,
  output logic [XLEN-1:0]      dbgData,
  output logic                 busy,
  output logic                 done,
  output logic                 illegalOp
);

  strobes_t           stb;
  logic               pcReached;
  logic               nextReached;
  logic [AW-1:0]      memAddr;
  logic [INSTR_W-1:0] memData;

  regcore_imem #(.WORDS(MEM_WORDS), .WIDTH(INSTR_W)) imem_i (
    .clk    (clk),
    .wrEn   (loadEn && !rstN),
    .wrAddr (loadAddr),
    .wrData (loadData),
    .rdEn   (stb.fetch),
    .rdAddr (memAddr),
    .rdData (memData)
  );

  regcore_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .pcReached   (pcReached),
    .nextReached (nextReached),
    .stb         (stb),
    .busy        (busy),
    .done        (done)
  );

  regcore_dpath #(.XLEN(XLEN), .MEM_WORDS(MEM_WORDS)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .progLen     (progLen),
    .memData     (memData),
    .memAddr     (memAddr),
    .dbgSel      (dbgSel),
    .dbgData     (dbgData),
    .pcReached   (pcReached),
    .nextReached (nextReached),
    .illegal     (illegalOp)
  );

endmodule

// File: tb/regcore_top_tb_top.sv
`timescale 1ns/1ps
module regcore_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [9:0]  loadAddr = '0;
  logic [31:0] loadData = '0;
  logic        start = 1'b0;
  logic [10:0] progLen = '0;
  logic [3:0]  dbgSel = '0;
  logic [31:0] dbgData;
  logic        busy;
  logic        done;
  logic        illegalOp;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] prog [16];

  always #2.5 clk = ~clk;

  regcore_top dut_i (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .start(start), .progLen(progLen),
    .dbgSel(dbgSel), .dbgData(dbgData), .busy(busy), .done(done),
    .illegalOp(illegalOp)
  );

  function automatic logic [31:0] enc(input int op, input int f1, input int f2, input int f3);
    return {8'(f3), 8'(f2), 8'(f1), 8'(op)};
  endfunction

  function automatic logic [31:0] model(input int op, input logic [31:0] a,
                                        input logic [31:0] b, input logic [7:0] imm);
    case (op)
      0:  return a & b;
      1:  return a ^ b;
      2:  return a - b;
      3:  return b - a;
      4:  return a + b;
      12: return a | b;
      13: return {24'd0, imm};
      14: return a & ~b;
      default: return ~{24'd0, imm};
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input int r, output logic [31:0] v);
    dbgSel = 4'(r);
    #0.5;
    v = dbgData;
  endtask

  task automatic loadProg(input int n);
    @(negedge clk);
    rstN = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      loadEn = 1'b1; loadAddr = 10'(i); loadData = prog[i];
    end
    @(negedge clk);
    loadEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic runProg(input int len, output int cyc);
    progLen = 11'(len);
    start = 1'b1;
    @(posedge clk);
    cyc = 1;
    @(negedge clk);
    start = 1'b0;
    while (!done && cyc < 400) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cyc;
    int ops [9] = '{0, 1, 2, 3, 4, 12, 13, 14, 15};
    logic [7:0] aImm [5] = '{8'd21, 8'd200, 8'd5, 8'h0F, 8'h80};
    logic       aInv [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    logic [7:0] bImm [5] = '{8'd21, 8'd7, 8'd9, 8'h33, 8'h01};
    logic       bInv [5] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};

    // R8 / R9: reset state
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R8 busy", 32'(busy), 32'd0);
    chk("R8 done", 32'(done), 32'd0);
    chk("R8 illegalOp", 32'(illegalOp), 32'd0);
    for (int r = 0; r < 16; r++) begin
      readReg(r, v);
      chk("R8 R9 reg after reset", v, 32'd0);
    end

    // R1: reference program
    prog[0] = 32'h0015010D; prog[1] = 32'h0015020D; prog[2] = 32'h02010304;
    chk("R1 encoding", enc(4, 3, 1, 2), 32'h02010304);
    loadProg(3);
    runProg(3, cyc);
    readReg(3, v);
    chk("R1 result", v, 32'd42);
    chk("R5 cycles three instr", 32'(cyc), 32'd11);
    readReg(15, v);
    chk("R4 final pc", v, 32'd3);

    // R2 / R3 sweep
    for (int p = 0; p < 5; p++) begin
      for (int k = 0; k < 9; k++) begin
        logic [31:0] aV, bV;
        aV = aInv[p] ? ~{24'd0, aImm[p]} : {24'd0, aImm[p]};
        bV = bInv[p] ? ~{24'd0, bImm[p]} : {24'd0, bImm[p]};
        prog[0] = enc(aInv[p] ? 15 : 13, 1, aImm[p], 8'hC3);
        prog[1] = enc(bInv[p] ? 15 : 13, 2, bImm[p], 0);
        if (ops[k] == 13 || ops[k] == 15) prog[2] = enc(ops[k], 3, bImm[p], 8'h5A);
        else                              prog[2] = enc(ops[k], 3, 1, 2);
        loadProg(3);
        runProg(3, cyc);
        readReg(3, v);
        chk((ops[k] == 13 || ops[k] == 15) ? "R3 immediate op" : "R2 register op",
            v, model(ops[k], aV, bV, bImm[p]));
        if (k == 0) chk("R6 no flag on legal code", 32'(illegalOp), 32'd0);
      end
    end

    // R4: pc as source and as destination
    prog[0] = enc(13, 1, 1, 0);
    prog[1] = enc(4, 2, 15, 0);
    prog[2] = enc(13, 15, 4, 0);
    prog[3] = enc(13, 5, 7, 0);
    prog[4] = enc(13, 6, 3, 0);
    loadProg(5);
    runProg(5, cyc);
    readReg(2, v);  chk("R4 pc read as source", v, 32'd2);
    readReg(5, v);  chk("R4 skipped word", v, 32'd0);
    readReg(6, v);  chk("R4 jump target ran", v, 32'd3);
    readReg(15, v); chk("R4 final pc after jump", v, 32'd5);
    chk("R5 cycles with jump", 32'(cyc), 32'd14);

    // R6: unknown opcode and bad register field
    prog[0] = enc(8'h20, 1, 5, 0);
    prog[1] = enc(13, 2, 3, 0);
    prog[2] = enc(4, 4, 8'h11, 2);
    loadProg(3);
    runProg(3, cyc);
    readReg(1, v); chk("R6 unknown opcode no write", v, 32'd0);
    readReg(4, v); chk("R6 bad field no write", v, 32'd0);
    readReg(2, v); chk("R6 later instr runs", v, 32'd3);
    chk("R6 flag set", 32'(illegalOp), 32'd1);
    repeat (3) @(negedge clk);
    chk("R6 flag sticky", 32'(illegalOp), 32'd1);

    // R7: load ignored outside reset
    prog[0] = enc(13, 1, 5, 0);
    loadProg(1);
    loadEn = 1'b1; loadAddr = 10'd0; loadData = enc(13, 1, 9, 0);
    @(negedge clk);
    loadEn = 1'b0;
    runProg(1, cyc);
    readReg(1, v); chk("R7 load with reset high ignored", v, 32'd5);

    // R10: zero length, start while done
    loadProg(1);
    runProg(0, cyc);
    chk("R10 zero length cycles", 32'(cyc), 32'd2);
    readReg(15, v); chk("R10 no instruction run", v, 32'd0);
    readReg(1, v);  chk("R10 no register written", v, 32'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    readReg(15, v); chk("R10 start in done ignored", v, 32'd0);
    chk("R5 done held", 32'(done), 32'd1);
    chk("R5 busy low in done", 32'(busy), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule